// File: doc/BRIEF.md
# Transfer Length Counters with Early Zero Detection

This block keeps the byte count of a memory-to-memory transfer. It holds two down-counters. The first is the length value that software programs and can read back. The second is a private copy that tracks how many bytes the write side still owes. A single host register write loads both counters with the same byte count. After that, the read-side counter drops by the transaction size each time a read beat completes. The write-side counter drops the same way on each completed write beat.

Each counter has a registered "reached zero" flag. The flag is not derived from the stored count. It is taken from the value the count is about to hold, so it rises on the same clock edge at which the count becomes zero. The transfer state machines that use these flags can therefore stop without spending an extra cycle on a compare. A host load always drops both flags for at least one cycle, even when the loaded value is zero. A flag then rises again only when a decrement lands the count on zero.

Top module: `dma_len_track`

## Requirements
- R1: In reset, both counts take the parameter LEN_RST. Each zero flag reads 1 when LEN_RST is zero and 0 otherwise.
- R2: The transaction size code sets the decrement step: code 0 gives 1 byte, code 1 gives 2 bytes, code 2 gives 4 bytes, and code 3 also gives 4 bytes.
- R3: When host_sel and host_we are both 1, both counts equal host_wdata one cycle later. If either of them is 0, the host data has no effect.
- R4: Without a host write, each cycle with rd_inc high lowers len_count by the step, modulo 2^LEN_W. The state of len_zero does not block this.
- R5: Without a host write, each cycle with wr_inc high lowers wlen_count by the step, but only while wlen_zero is 0. While wlen_zero is 1, wlen_count holds.
- R6: A zero flag becomes 1 on the same clock edge at which a decrement leaves its count at zero.
- R7: A host write makes both zero flags 0 in the next cycle, even when the value written is zero. They stay 0 until a decrement reaches zero.
- R8: A host write in the same cycle as rd_inc or wr_inc wins: the counts take the written value and the flags clear.
- R9: Once set, a zero flag stays 1 until the next host write or reset. This holds even when rd_inc keeps lowering (and wraps) len_count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host selects the length register |
| host_we | input | 1 | Host write enable |
| host_wdata | input | LEN_W | Byte count to load |
| rd_inc | input | 1 | One read beat completed this cycle |
| wr_inc | input | 1 | One write beat completed this cycle |
| xfer_size | input | 2 | Transaction size code (0:1, 1:2, 2 or 3:4 bytes) |
| len_count | output | LEN_W | Programmable length, host read-back value |
| wlen_count | output | LEN_W | Write-side remaining length |
| len_zero | output | 1 | Length has reached zero |
| wlen_zero | output | 1 | Write-side length has reached zero |

## Verification
Every output is a single register stage. A load, a decrement or a flag change driven in one cycle therefore shows up exactly one clock edge later, and the zero flag changes on the same edge as the count that triggers it. The bench changes inputs on the falling edge and samples all four outputs 1 ns after the following rising edge. Each vector's expected counts and flags thus describe the state right after that single edge. Reset values are checked while reset is still held, after one edge.

// File: rtl/dma_len_pkg.sv
package dma_len_pkg;
  localparam int STEP_W = 3;
  localparam int SIZE_W = 2;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } xfer_size_e;
endpackage

// File: rtl/dma_len_step.sv
module dma_len_step
  import dma_len_pkg::*;
(
  input  logic [SIZE_W-1:0] size_code,
  output logic [STEP_W-1:0] step_bytes
);
  always_comb begin
    unique case (xfer_size_e'(size_code))
      SZ_BYTE: step_bytes = STEP_W'(1);
      SZ_HALF: step_bytes = STEP_W'(2);
      SZ_WORD: step_bytes = STEP_W'(4);
      default: step_bytes = STEP_W'(4);
    endcase
  end
endmodule

// File: rtl/dma_len_cnt.sv
module dma_len_cnt
  import dma_len_pkg::*;
#(
  parameter int          W       = 16,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter bit          STOP_AT_ZERO = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [W-1:0]      load_val,
  input  logic              inc,
  input  logic [STEP_W-1:0] step,
  output logic [W-1:0]      count,
  output logic              zero
);
  localparam logic RST_ZERO = (RST_VAL == '0);

  logic         dec_en;
  logic [W-1:0] dec_val;
  logic         zero_next_p1;

  generate
    if (STOP_AT_ZERO) begin : g_gated
      assign dec_en = inc && !zero;
    end else begin : g_free
      assign dec_en = inc;
    end
  endgenerate

  assign dec_val      = count - W'(step);
  assign zero_next_p1 = dec_en && (dec_val == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= RST_VAL;
    end else if (load) begin
      count <= load_val;
    end else if (dec_en) begin
      count <= dec_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zero <= RST_ZERO;
    end else if (load) begin
      zero <= 1'b0;
    end else if (zero_next_p1) begin
      zero <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_len_track.sv
module dma_len_track
  import dma_len_pkg::*;
#(
  parameter int               LEN_W   = 16,
  parameter logic [LEN_W-1:0] LEN_RST = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic [LEN_W-1:0]  host_wdata,
  input  logic              rd_inc,
  input  logic              wr_inc,
  input  logic [SIZE_W-1:0] xfer_size,
  output logic [LEN_W-1:0]  len_count,
  output logic [LEN_W-1:0]  wlen_count,
  output logic              len_zero,
  output logic              wlen_zero
);
  logic              host_load;
  logic [STEP_W-1:0] step;

  assign host_load = host_sel && host_we;

  dma_len_step u_step (
    .size_code  (xfer_size),
    .step_bytes (step)
  );

  dma_len_cnt #(
    .W            (LEN_W),
    .RST_VAL      (LEN_RST),
    .STOP_AT_ZERO (1'b0)
  ) u_rd_len (
    .clk      (clk),
    .rst      (rst),
    .load     (host_load),
    .load_val (host_wdata),
    .inc      (rd_inc),
    .step     (step),
    .count    (len_count),
    .zero     (len_zero)
  );

  dma_len_cnt #(
    .W            (LEN_W),
    .RST_VAL      (LEN_RST),
    .STOP_AT_ZERO (1'b1)
  ) u_wr_len (
    .clk      (clk),
    .rst      (rst),
    .load     (host_load),
    .load_val (host_wdata),
    .inc      (wr_inc),
    .step     (step),
    .count    (wlen_count),
    .zero     (wlen_zero)
  );
endmodule

// File: rtl/dma_len_track_chk.sv
module dma_len_track_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         host_sel,
  input logic         host_we,
  input logic [W-1:0] host_wdata,
  input logic         rd_inc,
  input logic         wr_inc,
  input logic [1:0]   xfer_size,
  input logic [W-1:0] len_count,
  input logic [W-1:0] wlen_count,
  input logic         len_zero,
  input logic         wlen_zero
);
  logic         wr_hit;
  logic [W-1:0] chk_step;

  assign wr_hit   = host_sel && host_we;
  assign chk_step = (xfer_size == 2'd0) ? W'(1) :
                    (xfer_size == 2'd1) ? W'(2) : W'(4);

  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (len_count == $past(host_wdata)) && (wlen_count == $past(host_wdata)));

  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> !len_zero && !wlen_zero);

  a_r4_dec: assert property (@(posedge clk) disable iff (rst)
    (!wr_hit && rd_inc) |=> len_count == $past(len_count) - $past(chk_step));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_hit && wlen_zero) |=> $stable(wlen_count) && wlen_zero);

  a_r6_set: assert property (@(posedge clk) disable iff (rst)
    (!wr_hit && rd_inc && len_count == chk_step) |=> len_zero && len_count == '0);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_hit && len_zero) |=> len_zero);
endmodule

bind dma_len_track dma_len_track_chk #(.W(LEN_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_sel   (host_sel),
  .host_we    (host_we),
  .host_wdata (host_wdata),
  .rd_inc     (rd_inc),
  .wr_inc     (wr_inc),
  .xfer_size  (xfer_size),
  .len_count  (len_count),
  .wlen_count (wlen_count),
  .len_zero   (len_zero),
  .wlen_zero  (wlen_zero)
);

// File: tb/sim_dma_len_track.sv
`timescale 1ns/1ps
module sim_dma_len_track;
  localparam int W = 16;
  localparam int NV = 16;

  typedef struct packed {
    logic         sel;
    logic         we;
    logic [W-1:0] wdata;
    logic         rd;
    logic         wr;
    logic [1:0]   size;
    logic [W-1:0] elen;
    logic [W-1:0] ewlen;
    logic         elz;
    logic         ewlz;
  } vec_t;

  localparam logic [55:0] VEC [0:NV-1] = '{
    {1'b1,1'b1,16'd10, 1'b0,1'b0,2'd0, 16'd10,16'd10, 1'b0,1'b0},
    {1'b0,1'b0,16'd0,  1'b1,1'b1,2'd0, 16'd9, 16'd9,  1'b0,1'b0},
    {1'b0,1'b0,16'd0,  1'b1,1'b0,2'd1, 16'd7, 16'd9,  1'b0,1'b0},
    {1'b0,1'b0,16'd0,  1'b0,1'b1,2'd2, 16'd7, 16'd5,  1'b0,1'b0},
    {1'b0,1'b0,16'd0,  1'b1,1'b1,2'd2, 16'd3, 16'd1,  1'b0,1'b0},
    {1'b0,1'b0,16'd0,  1'b1,1'b1,2'd0, 16'd2, 16'd0,  1'b0,1'b1},
    {1'b0,1'b0,16'd0,  1'b0,1'b1,2'd0, 16'd2, 16'd0,  1'b0,1'b1},
    {1'b0,1'b0,16'd0,  1'b1,1'b0,2'd1, 16'd0, 16'd0,  1'b1,1'b1},
    {1'b0,1'b0,16'd0,  1'b1,1'b0,2'd0, 16'd65535,16'd0,1'b1,1'b1},
    {1'b1,1'b1,16'd0,  1'b1,1'b1,2'd2, 16'd0, 16'd0,  1'b0,1'b0},
    {1'b0,1'b0,16'd0,  1'b0,1'b0,2'd0, 16'd0, 16'd0,  1'b0,1'b0},
    {1'b0,1'b1,16'd99, 1'b0,1'b0,2'd0, 16'd0, 16'd0,  1'b0,1'b0},
    {1'b1,1'b0,16'd99, 1'b0,1'b0,2'd0, 16'd0, 16'd0,  1'b0,1'b0},
    {1'b1,1'b1,16'd6,  1'b0,1'b0,2'd0, 16'd6, 16'd6,  1'b0,1'b0},
    {1'b0,1'b0,16'd0,  1'b1,1'b1,2'd3, 16'd2, 16'd2,  1'b0,1'b0},
    {1'b0,1'b0,16'd0,  1'b1,1'b1,2'd1, 16'd0, 16'd0,  1'b1,1'b1}
  };

  localparam string TAG [0:NV-1] = '{
    "R3 load", "R4 byte step", "R2 half step", "R5 word step",
    "R2 word step", "R6 write side zero", "R5 gated at zero", "R6 read side zero",
    "R9 flag holds on wrap", "R8 write wins", "R7 flag stays clear", "R3 no select",
    "R3 no write enable", "R3 reload", "R2 code 3 step", "R6 both zero"
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         host_sel = 1'b0, host_we = 1'b0;
  logic [W-1:0] host_wdata = '0;
  logic         rd_inc = 1'b0, wr_inc = 1'b0;
  logic [1:0]   xfer_size = 2'd0;
  logic [W-1:0] len_count, wlen_count, b_len, b_wlen;
  logic         len_zero, wlen_zero, b_lz, b_wlz;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma_len_track #(.LEN_W(W)) u0 (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_we(host_we),
    .host_wdata(host_wdata), .rd_inc(rd_inc), .wr_inc(wr_inc),
    .xfer_size(xfer_size), .len_count(len_count), .wlen_count(wlen_count),
    .len_zero(len_zero), .wlen_zero(wlen_zero)
  );

  dma_len_track #(.LEN_W(W), .LEN_RST(16'd5)) u1 (
    .clk(clk), .rst(rst), .host_sel(1'b0), .host_we(1'b0),
    .host_wdata('0), .rd_inc(1'b0), .wr_inc(1'b0),
    .xfer_size(2'd0), .len_count(b_len), .wlen_count(b_wlen),
    .len_zero(b_lz), .wlen_zero(b_wlz)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic [W-1:0] el, input logic [W-1:0] ew,
                           input logic ez, input logic ewz);
    check({tag, " len_count"},  len_count,  el);
    check({tag, " wlen_count"}, wlen_count, ew);
    check({tag, " len_zero"},   W'(len_zero),  W'(ez));
    check({tag, " wlen_zero"},  W'(wlen_zero), W'(ewz));
  endtask

  task automatic drive(input logic s, input logic w, input logic [W-1:0] d,
                       input logic r, input logic x, input logic [1:0] z);
    @(negedge clk);
    host_sel = s; host_we = w; host_wdata = d;
    rd_inc = r; wr_inc = x; xfer_size = z;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 reset zero value", 16'd0, 16'd0, 1'b1, 1'b1);
    check("R1 reset nonzero len", b_len, 16'd5);
    check("R1 reset nonzero wlen", b_wlen, 16'd5);
    check("R1 reset nonzero len_zero", W'(b_lz), W'(0));
    check("R1 reset nonzero wlen_zero", W'(b_wlz), W'(0));
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(VEC[i]);
      drive(v.sel, v.we, v.wdata, v.rd, v.wr, v.size);
      check_all(TAG[i], v.elen, v.ewlen, v.elz, v.ewlz);
    end

    drive(1'b1, 1'b1, 16'd40, 1'b0, 1'b0, 2'd0);
    check_all("R3 load before reset", 16'd40, 16'd40, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    drive(1'b1, 1'b1, 16'd77, 1'b1, 1'b1, 2'd2);
    check_all("R1 reset over host write", 16'd0, 16'd0, 1'b1, 1'b1);
    @(negedge clk);
    rst = 1'b0;

    drive(1'b1, 1'b1, 16'd1, 1'b0, 1'b0, 2'd0);
    drive(1'b0, 1'b0, 16'd0, 1'b1, 1'b0, 2'd0);
    check_all("R6 read only zero", 16'd0, 16'd1, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 16'd0, 1'b0, 1'b1, 2'd0);
    check_all("R6 write only zero", 16'd0, 16'd0, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 16'd0, 1'b0, 1'b0, 2'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule